// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and calendar date as packed BCD counters: seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year. A free-running enable at 32.768 kHz feeds a sub-second prescaler. The prescaler issues one tick per second, and that tick ripples through the carry chain. The date rollover follows the length of the current month, and February gains a 29th day in leap years.

Each field has a load input. A single load strobe writes all of them in one cycle and restarts the prescaler. All fields stay visible on outputs so an outer shadow stage can capture them. Two control bits live inside the time fields. The top bit of the seconds byte freezes timekeeping when set. Bit 6 of the day byte enables a test mode, in which the seconds LSB seen on the output flips at 1/64 of the input enable rate (512 Hz for a 32.768 kHz enable).

Top module: `bcd_calendar_chain`

## Requirements
- R1: After reset the outputs read seconds 0x80 (halt bit set, count 00), minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: With `loadEn` high at a clock edge, every field takes its load input, and the new values show on the outputs after that edge. Unused bits are written as zero. The load wins over a tick in the same cycle and clears the prescaler and the test phase.
- R3: With the halt bit clear, seconds advance by one exactly TICK_DIV cycles with `tick32k` high after a load. Cycles with `tick32k` low do not count.
- R4: Counters roll over in BCD. A units digit of 9 carries into the tens digit. Seconds 59 wraps to 00 and increments minutes. Minutes 59 wraps to 00 and increments hours. Hours 23 wraps to 00 and advances both the date and the weekday.
- R5: The date wraps to 01 after 30 in months 0x04, 0x06, 0x09 and 0x11, and after 31 in every other month except February. When the date wraps, the month advances.
- R6: February ends at date 0x29 when the BCD year is divisible by four (year 0x00 included) and at 0x28 otherwise.
- R7: Month 0x12 wraps to 0x01 and increments the year. Year 0x99 wraps to 0x00.
- R8: The weekday counts 01 to 07 and wraps from 07 back to 01.
- R9: While seconds bit 7 (halt) is 1, every field and the prescaler hold their values. A load that clears the bit restarts counting.
- R10: Day bit 6 (test) is stored and read back. When it is set and the halt bit is clear, output seconds bit 0 is inverted during alternate spans of TEST_DIV enabled cycles, starting un-inverted after a load. When test is clear or halt is set, output bit 0 is the true count.
- R11: Bits not in a field read zero: minutes bit 7, hours bits 7:6, day bits 7 and 5:3, date bits 7:6, month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| loadEn | input | 1 | Parallel load strobe for all fields |
| ldSec | input | 8 | Load value: halt bit 7, BCD seconds 6:0 |
| ldMin | input | 8 | Load value: BCD minutes |
| ldHour | input | 8 | Load value: BCD hours |
| ldDay | input | 8 | Load value: test bit 6, weekday 2:0 |
| ldDate | input | 8 | Load value: BCD day of month |
| ldMonth | input | 8 | Load value: BCD month |
| ldYear | input | 8 | Load value: BCD year |
| secOut | output | 8 | Halt bit and BCD seconds (bit 0 toggled in test mode) |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | BCD hours |
| dayOut | output | 8 | Test bit and weekday |
| dateOut | output | 8 | BCD day of month |
| monthOut | output | 8 | BCD month |
| yearOut | output | 8 | BCD year |

## Verification
A table of preloaded times sits one tick before each rollover. This separates a plain units increment, a digit carry, and each level of the minute, hour, date, month and year chain. February is tried with years 23, 24, 00, 12 and 18, so both the even-tens and odd-tens leap digit patterns are covered, along with 30-day months, 31-day months and the year wrap. Directed runs gate `tick32k` low, hold the halt bit across many cycles, and sample the test-mode LSB at points inside each toggle span. These runs show that the prescaler counts only enabled cycles and restarts on load. They also show that the toggle is gated by both control bits.

// File: rtl/calPkg.sv
package calPkg;

  typedef struct packed {
    logic loadNow;
    logic secTick;
    logic testPhase;
  } calStrobeT;

  localparam logic [7:0] SEC_MASK   = 8'h7F;
  localparam logic [7:0] MIN_MASK   = 8'h7F;
  localparam logic [7:0] HOUR_MASK  = 8'h3F;
  localparam logic [7:0] DAY_MASK   = 8'h07;
  localparam logic [7:0] DATE_MASK  = 8'h3F;
  localparam logic [7:0] MONTH_MASK = 8'h1F;

  // Next BCD value, wrapping from lastVal to firstVal
  function automatic logic [7:0] bcdNext(input logic [7:0] v,
                                         input logic [7:0] lastVal,
                                         input logic [7:0] firstVal);
    logic [7:0] r;
    if (v == lastVal)        r = firstVal;
    else if (v[3:0] == 4'h9) r = {v[7:4] + 4'd1, 4'h0};
    else                     r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by four, read straight from the BCD digits
  function automatic logic isLeap(input logic [7:0] yr);
    logic r;
    if (!yr[4]) r = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    else        r = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    return r;
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic leap);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int TEST_DIV = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick32k,
  input  logic      loadEn,
  input  logic      stopped,
  output calStrobeT strb
);
  localparam int CNT_W = $clog2(TICK_DIV);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] TEST_MASK = CNT_W'(TEST_DIV - 1);

  logic [CNT_W-1:0] preCnt;
  logic             testPhase;
  logic             runEn;
  logic             testHit;

  assign runEn   = tick32k && !stopped && !loadEn;
  assign testHit = (preCnt & TEST_MASK) == TEST_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      testPhase <= 1'b0;
    end else if (loadEn) begin
      preCnt    <= '0;
      testPhase <= 1'b0;
    end else if (runEn) begin
      preCnt <= (preCnt == CNT_LAST) ? '0 : preCnt + CNT_W'(1);
      if (testHit) testPhase <= ~testPhase;
    end
  end

  always_comb begin
    strb.loadNow   = loadEn;
    strb.secTick   = runEn && (preCnt == CNT_LAST);
    strb.testPhase = testPhase;
  end

  // R2
  load_clears_prescaler_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (preCnt == '0) && !testPhase);

  // R9
  halt_holds_prescaler_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && !loadEn) |=> $stable(preCnt) && $stable(testPhase));

  // R3
  tick_restarts_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.secTick |=> (preCnt == '0));

endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobeT  strb,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [7:0] ldDay,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMonth,
  input  logic [7:0] ldYear,
  output logic       stopped,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut
);
  logic [7:0] secReg, minReg, hourReg, dayReg, dateReg, monthReg, yearReg;
  logic       haltReg, testReg;
  logic [7:0] lastDate;
  logic       secWrap, minWrap, hourWrap, dateWrap, monthWrap;

  always_comb begin
    lastDate  = monthLast(monthReg, isLeap(yearReg));
    secWrap   = secReg == 8'h59;
    minWrap   = secWrap && (minReg == 8'h59);
    hourWrap  = minWrap && (hourReg == 8'h23);
    dateWrap  = hourWrap && (dateReg == lastDate);
    monthWrap = dateWrap && (monthReg == 8'h12);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg   <= 8'h00;
      haltReg  <= 1'b1;
      minReg   <= 8'h00;
      hourReg  <= 8'h00;
      dayReg   <= 8'h01;
      testReg  <= 1'b0;
      dateReg  <= 8'h01;
      monthReg <= 8'h01;
      yearReg  <= 8'h00;
    end else if (strb.loadNow) begin
      secReg   <= ldSec & SEC_MASK;
      haltReg  <= ldSec[7];
      minReg   <= ldMin & MIN_MASK;
      hourReg  <= ldHour & HOUR_MASK;
      dayReg   <= ldDay & DAY_MASK;
      testReg  <= ldDay[6];
      dateReg  <= ldDate & DATE_MASK;
      monthReg <= ldMonth & MONTH_MASK;
      yearReg  <= ldYear;
    end else if (strb.secTick) begin
      secReg <= bcdNext(secReg, 8'h59, 8'h00);
      if (secWrap)  minReg  <= bcdNext(minReg, 8'h59, 8'h00);
      if (minWrap)  hourReg <= bcdNext(hourReg, 8'h23, 8'h00);
      if (hourWrap) begin
        dayReg  <= bcdNext(dayReg, 8'h07, 8'h01);
        dateReg <= bcdNext(dateReg, lastDate, 8'h01);
      end
      if (dateWrap)  monthReg <= bcdNext(monthReg, 8'h12, 8'h01);
      if (monthWrap) yearReg  <= bcdNext(yearReg, 8'h99, 8'h00);
    end
  end

  assign stopped  = haltReg;
  assign secOut   = {haltReg, secReg[6:1],
                     secReg[0] ^ (testReg && !haltReg && strb.testPhase)};
  assign minOut   = minReg;
  assign hourOut  = hourReg;
  assign dayOut   = {1'b0, testReg, 3'b000, dayReg[2:0]};
  assign dateOut  = dateReg;
  assign monthOut = monthReg;
  assign yearOut  = yearReg;

  // R9
  halt_freezes_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltReg && !strb.loadNow) |=> $stable(secReg) && $stable(minReg) &&
      $stable(hourReg) && $stable(dateReg) && $stable(monthReg) && $stable(yearReg));

  // R4
  sec_digits_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secReg[3:0] <= 4'h9) && (secReg <= 8'h59) && (minReg <= 8'h59) && (hourReg <= 8'h23));

  // R5
  date_wrap_moves_month_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.secTick && !strb.loadNow && hourWrap && dateReg == lastDate)
      |=> (dateReg == 8'h01) && (monthReg != $past(monthReg)));

  // R8
  weekday_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.secTick && !strb.loadNow && hourWrap && dayReg == 8'h07) |=> (dayReg == 8'h01));

endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain
  import calPkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int TEST_DIV = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       loadEn,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [7:0] ldDay,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMonth,
  input  logic [7:0] ldYear,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut
);
  calStrobeT strb;
  logic      stopped;

  calCtrl #(.TICK_DIV(TICK_DIV), .TEST_DIV(TEST_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .loadEn(loadEn),
    .stopped(stopped), .strb(strb)
  );

  calDatapath uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDay(ldDay),
    .ldDate(ldDate), .ldMonth(ldMonth), .ldYear(ldYear),
    .stopped(stopped),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dayOut(dayOut),
    .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
  );

endmodule

// File: tb/sim_bcd_calendar_chain.sv
module sim_bcd_calendar_chain;
  localparam int TDIV = 16;
  localparam int XDIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick32k = 1'b1;
  logic loadEn = 1'b0;
  logic [7:0] ldSec = '0, ldMin = '0, ldHour = '0, ldDay = '0;
  logic [7:0] ldDate = '0, ldMonth = '0, ldYear = '0;
  logic [7:0] secOut, minOut, hourOut, dayOut, dateOut, monthOut, yearOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_calendar_chain #(.TICK_DIV(TDIV), .TEST_DIV(XDIV)) u0 (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .loadEn(loadEn),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDay(ldDay),
    .ldDate(ldDate), .ldMonth(ldMonth), .ldYear(ldYear),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dayOut(dayOut),
    .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut)
  );

  // load fields {sec,min,hour,day,date,month,year} then expected after one tick
  localparam logic [111:0] VEC [0:15] = '{
    112'h00_00_00_03_15_06_24_01_00_00_03_15_06_24,
    112'h09_00_00_03_15_06_24_10_00_00_03_15_06_24,
    112'h59_00_00_03_15_06_24_00_01_00_03_15_06_24,
    112'h59_59_05_03_15_06_24_00_00_06_03_15_06_24,
    112'h59_59_23_03_15_06_24_00_00_00_04_16_06_24,
    112'h59_59_23_07_30_04_24_00_00_00_01_01_05_24,
    112'h59_59_23_02_30_05_24_00_00_00_03_31_05_24,
    112'h59_59_23_02_28_02_23_00_00_00_03_01_03_23,
    112'h59_59_23_02_28_02_24_00_00_00_03_29_02_24,
    112'h59_59_23_02_29_02_24_00_00_00_03_01_03_24,
    112'h59_59_23_02_28_02_00_00_00_00_03_29_02_00,
    112'h59_59_23_02_28_02_18_00_00_00_03_01_03_18,
    112'h59_59_23_02_28_02_12_00_00_00_03_29_02_12,
    112'h59_59_23_05_31_12_99_00_00_00_06_01_01_00,
    112'h59_59_23_05_30_11_10_00_00_00_06_01_12_10,
    112'h59_59_23_05_31_01_10_00_00_00_06_01_02_10
  };
  localparam string TAG [0:15] = '{
    "R3", "R4", "R4", "R4", "R4", "R8", "R5", "R6",
    "R6", "R6", "R6", "R6", "R6", "R7", "R5", "R5"
  };

  function automatic logic [55:0] allOut();
    return {secOut, minOut, hourOut, dayOut, dateOut, monthOut, yearOut};
  endfunction

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doLoad(input logic [55:0] v);
    @(negedge clk);
    {ldSec, ldMin, ldHour, ldDay, ldDate, ldMonth, ldYear} = v;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R1 reset values
    check("R1", allOut(), 56'h80_00_00_01_01_01_00);
    waitN(40);
    // R9 halted after reset: nothing moves
    check("R9", allOut(), 56'h80_00_00_01_01_01_00);

    // R2 load with unused bits set; R11 they read back as zero
    doLoad(56'h12_A5_C7_B9_C5_E3_42);
    check("R11", allOut(), 56'h12_25_07_01_05_03_42);

    // vector table: one tick from each preload
    for (int i = 0; i < 16; i++) begin
      doLoad(VEC[i][111:56]);
      waitN(TDIV - 1);
      check("R2", {secOut}, VEC[i][111:104]);
      waitN(1);
      check(TAG[i], allOut(), VEC[i][55:0]);
    end

    // R3 prescaler counts only enabled cycles
    doLoad(56'h10_00_00_01_01_01_24);
    tick32k = 1'b0;
    waitN(30);
    check("R3", {secOut}, 8'h10);
    tick32k = 1'b1;
    waitN(TDIV - 1);
    check("R3", {secOut}, 8'h10);
    waitN(1);
    check("R3", {secOut}, 8'h11);
    waitN(TDIV);
    check("R3", {secOut}, 8'h12);

    // R9 halt bit holds every field, clearing it resumes
    doLoad(56'hB0_59_23_07_31_12_99);
    waitN(40);
    check("R9", allOut(), 56'hB0_59_23_07_31_12_99);
    doLoad(56'h30_00_00_01_01_01_24);
    waitN(TDIV);
    check("R9", {secOut}, 8'h31);

    // R10 test toggle: flips after every XDIV enabled cycles
    doLoad(56'h20_00_00_42_01_01_24);
    check("R10", {dayOut}, 8'h42);
    waitN(2);
    check("R10", {secOut}, 8'h20);
    waitN(3);
    check("R10", {secOut}, 8'h21);
    waitN(4);
    check("R10", {secOut}, 8'h20);
    waitN(7);
    check("R10", {secOut}, 8'h21);
    // R10 halted: no toggle
    doLoad(56'hA0_00_00_42_01_01_24);
    waitN(5);
    check("R10", {secOut}, 8'hA0);
    waitN(4);
    check("R10", {secOut}, 8'hA0);
    // R10 test bit clear: no toggle
    doLoad(56'h20_00_00_02_01_01_24);
    waitN(5);
    check("R10", {secOut}, 8'h20);

    // R2 load during running count restarts the prescaler
    doLoad(56'h40_00_00_01_01_01_24);
    waitN(10);
    doLoad(56'h40_00_00_01_01_01_24);
    waitN(TDIV - 1);
    check("R2", {secOut}, 8'h40);
    waitN(1);
    check("R2", {secOut}, 8'h41);

    finish();
  end

endmodule